// File: doc/BRIEF.md
# Strobe-Controlled FIFO Buffer

This block is a first-in/first-out buffer of 9-bit words whose writes and reads are requested by two active-low strobe pins rather than by clock-qualified enables. Each strobe passes through a two-flop synchroniser into the system clock domain. A word is committed to storage when the write strobe returns high. The head word is consumed when the read strobe returns high. Three status outputs report empty, full and more-than-half-full occupancy. The output bus is modelled as data plus an output-enable, which stands in for a three-state driver.

Two flow-through cases are supported. In read flow-through, a read strobe may already be low when the buffer is empty. A word written then appears on the output at once and is consumed when the read strobe rises. In write flow-through, a write strobe may already be low when the buffer is full. A read then frees a slot: the full flag drops for one cycle and comes back to reserve that slot, and the pending word is stored when the write strobe rises.

Top module: `strobe_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer: afterwards the empty flag is 1, the full flag, the half-full flag and the output-enable are 0.
- R2: A word on `din` is stored on the rising edge of `wr_n` when space exists, and words are read back in the order they were written.
- R3: `dout_oe` is 1 only while `rd_n` is low and the buffer holds at least one word. While it is 1, `dout` shows the oldest stored word. The rising edge of `rd_n` removes that word.
- R4: Read flow-through: if `rd_n` is held low while empty and a word is then written, `dout_oe` goes to 1 with that word on `dout` and empty goes to 0. After `rd_n` rises, empty returns to 1 and `dout_oe` to 0.
- R5: The full flag is 1 when DEPTH words are stored. A write strobe that rises while the buffer is full and no read rises in the same cycle is ignored, and no word is added.
- R6: The half-full flag is 1 exactly when more than DEPTH/2 words are stored.
- R7: Write flow-through: a read from a full buffer while `wr_n` is low clears the full flag for exactly one cycle, then sets it again. The pending word is stored when `wr_n` rises, and it is read out last.
- R8: A read strobe that rises while the buffer is empty is ignored: `dout_oe` stays 0 and later data is unaffected.
- R9: When read and write edges are detected in the same cycle and the buffer holds data, both are honoured and the occupancy is unchanged.
- R10: A strobe is sampled high at some clock edge E1. Its effect on the flags is visible after the third rising clock edge counted from E1, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe; word committed on its rising edge |
| rd_n | input | 1 | Active-low read strobe; head word consumed on its rising edge |
| din | input | 9 | Write data, held stable around the write strobe's rising edge |
| dout | output | 9 | Oldest stored word |
| dout_oe | output | 1 | Output-enable for `dout` (three-state driver model) |
| empty | output | 1 | No words stored |
| full | output | 1 | Buffer full, or a freed slot is reserved for a pending write |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
The assertions rely on three assumptions about the inputs. Each strobe stays at a level long enough for the synchroniser to carry it, so that no more than one edge is detected per cycle. `din` does not change during the cycles in which a write edge is being detected. Reset is held for at least one clock edge. The stimulus meets these by keeping every strobe level for four clock cycles. It drives all inputs at the falling clock edge, and it changes `din` only while the write strobe is high and settled.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // Synchronised strobe view: level and one-cycle rising-edge pulse
    typedef struct packed {
        logic rise;
        logic low;
    } strobe_ev_t;

    typedef struct packed {
        logic empty;
        logic full;
        logic half;
    } sfifo_flags_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_PUSH  = 2'b10,
        OP_POP   = 2'b01,
        OP_SWAP  = 2'b11
    } sfifo_op_e;

    function automatic sfifo_op_e decode_op(input logic push, input logic pop);
        return sfifo_op_e'({push, pop});
    endfunction

endpackage

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync
    import sfifo_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_n,
    output strobe_ev_t ev
);

    localparam int CHAIN_W = (STAGES < 2) ? 2 : STAGES;

    logic [CHAIN_W-1:0] chain_q;
    logic               prev_q;
    logic               synced;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], strobe_n};
            prev_q  <= synced;
        end
    end

    assign synced  = chain_q[CHAIN_W-1];
    assign ev.low  = ~synced;
    assign ev.rise = synced & ~prev_q;

    // R10
    rise_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> !ev.rise);

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_ev_t    wr_ev,
    input  strobe_ev_t    rd_ev,
    output logic          wr_commit,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output sfifo_flags_t  flags
);

    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LAST_LVL = CW'(DEPTH - 1);

    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          freed_q;
    logic          reserve_q, reserve_d;
    logic          has_data, has_room;
    logic          rd_ok, wr_ok;
    sfifo_op_e     op;

    assign has_data = (cnt_q != '0);
    assign has_room = (cnt_q != FULL_LVL);
    assign rd_ok    = rd_ev.rise & has_data;
    assign wr_ok    = wr_ev.rise & (has_room | rd_ok);
    assign op       = decode_op(wr_ok, rd_ok);

    always_comb begin
        unique case (op)
            OP_PUSH: cnt_d = cnt_q + 1'b1;
            OP_POP:  cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    // Slot reservation for a write strobe already low when a full buffer drains by one
    always_comb begin
        if (wr_ev.rise || rd_ev.rise) begin
            reserve_d = 1'b0;
        end else if (freed_q && wr_ev.low) begin
            reserve_d = 1'b1;
        end else begin
            reserve_d = reserve_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q    <= '0;
            rptr_q    <= '0;
            cnt_q     <= '0;
            freed_q   <= 1'b0;
            reserve_q <= 1'b0;
        end else begin
            if (wr_ok) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (rd_ok) begin
                rptr_q <= rptr_q + 1'b1;
            end
            cnt_q     <= cnt_d;
            freed_q   <= (op == OP_POP) & ~has_room;
            reserve_q <= reserve_d;
        end
    end

    assign wr_commit   = wr_ok;
    assign waddr       = wptr_q;
    assign raddr       = rptr_q;
    assign flags.empty = ~has_data;
    assign flags.full  = ~has_room | (reserve_q & (cnt_q == LAST_LVL));
    assign flags.half  = (cnt_q > HALF_LVL);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (cnt_q == '0) && (wptr_q == rptr_q));

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_LVL);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (!has_room && wr_ev.rise && !rd_ev.rise) |=> $stable(wptr_q) && $stable(cnt_q));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (!has_data && rd_ev.rise) |=> $stable(rptr_q));

    // R9
    swap_keeps_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ev.rise && rd_ev.rise && has_data) |=> $stable(cnt_q));

    // R7
    reserve_only_near_full_chk: assert property (@(posedge clk) disable iff (rst)
        reserve_q |-> (cnt_q == LAST_LVL));

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH       = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic             dout_oe,
    output logic             empty,
    output logic             full,
    output logic             half_full
);

    localparam int AW = $clog2(DEPTH);

    strobe_ev_t    wr_ev, rd_ev;
    sfifo_flags_t  flags;
    logic          wr_commit;
    logic [AW-1:0] waddr, raddr;
    word_t         head;

    sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) wr_sync_i (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (wr_n),
        .ev       (wr_ev)
    );

    sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) rd_sync_i (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (rd_n),
        .ev       (rd_ev)
    );

    sfifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .wr_ev     (wr_ev),
        .rd_ev     (rd_ev),
        .wr_commit (wr_commit),
        .waddr     (waddr),
        .raddr     (raddr),
        .flags     (flags)
    );

    sfifo_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
        .clk   (clk),
        .we    (wr_commit),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (head)
    );

    assign dout      = head;
    assign dout_oe   = rd_ev.low & ~flags.empty;
    assign empty     = flags.empty;
    assign full      = flags.full;
    assign half_full = flags.half;

    // R3
    oe_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> !empty);

    // R6
    half_implies_data_chk: assert property (@(posedge clk) disable iff (rst)
        half_full |-> !empty);

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;

    localparam int DEPTH = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_oe, empty, full, half_full;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .din       (din),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    // op[20:19] (0 write, 1 read, 2 both), data[18:10], expected read word[9:1], expected empty[0]
    localparam logic [20:0] VEC [9] = '{
        {2'd0, 9'h101, 9'h000, 1'b0},
        {2'd0, 9'h0A5, 9'h000, 1'b0},
        {2'd1, 9'h000, 9'h101, 1'b0},
        {2'd0, 9'h1FF, 9'h000, 1'b0},
        {2'd2, 9'h033, 9'h0A5, 1'b0},
        {2'd1, 9'h000, 9'h1FF, 1'b0},
        {2'd1, 9'h000, 9'h033, 1'b1},
        {2'd0, 9'h000, 9'h000, 1'b0},
        {2'd1, 9'h000, 9'h000, 1'b1}
    };

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) % 512);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] d);
        din  = d;
        wr_n = 1'b0;
        wait_cyc(4);
        wr_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic do_read(output logic [8:0] q, output logic oe);
        rd_n = 1'b0;
        wait_cyc(4);
        q  = dout;
        oe = dout_oe;
        rd_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic do_both(input logic [8:0] d, output logic [8:0] q, output logic oe);
        din  = d;
        wr_n = 1'b0;
        rd_n = 1'b0;
        wait_cyc(4);
        q  = dout;
        oe = dout_oe;
        wr_n = 1'b1;
        rd_n = 1'b1;
        wait_cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [8:0] q;
        logic       oe;
        bit         saw_low;

        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R1 reset state
        check(empty == 1'b1, "R1", "empty after reset", empty, 1);
        check(full == 1'b0, "R1", "full after reset", full, 0);
        check(half_full == 1'b0, "R1", "half after reset", half_full, 0);
        check(dout_oe == 1'b0, "R1", "oe after reset", dout_oe, 0);

        // R10 exact latency from strobe rise to flag change
        din  = 9'h0F0;
        wr_n = 1'b0;
        wait_cyc(4);
        wr_n = 1'b1;
        wait_cyc(2);
        check(empty == 1'b1, "R10", "empty after two edges", empty, 1);
        wait_cyc(1);
        check(empty == 1'b0, "R10", "empty after three edges", empty, 0);
        wait_cyc(3);
        do_read(q, oe);
        check(q == 9'h0F0, "R10", "latency word", q, 9'h0F0);

        // Vector table: R2 writes, R3 reads, R9 simultaneous strobes
        foreach (VEC[k]) begin
            logic [1:0] vop;
            logic [8:0] vd, vexp;
            logic       vemp;
            {vop, vd, vexp, vemp} = VEC[k];
            if (vop == 2'd0) begin
                do_write(vd);
                check(empty == vemp, "R2", "empty after write", empty, vemp);
            end else if (vop == 2'd1) begin
                do_read(q, oe);
                check(q == vexp, "R3", "read word", q, vexp);
                check(oe == 1'b1, "R3", "oe during read", oe, 1);
                check(empty == vemp, "R3", "empty after read", empty, vemp);
            end else begin
                do_both(vd, q, oe);
                check(q == vexp, "R9", "word during both strobes", q, vexp);
                check(empty == vemp, "R9", "empty after both strobes", empty, vemp);
            end
        end

        // R8 read strobe on empty buffer is ignored
        do_read(q, oe);
        check(oe == 1'b0, "R8", "oe on empty read", oe, 0);
        check(empty == 1'b1, "R8", "empty after empty read", empty, 1);
        do_write(9'h155);
        do_read(q, oe);
        check(q == 9'h155, "R8", "word after ignored read", q, 9'h155);
        check(empty == 1'b1, "R8", "empty after drain", empty, 1);

        // R4 read flow-through
        rd_n = 1'b0;
        wait_cyc(4);
        check(dout_oe == 1'b0, "R4", "oe while empty", dout_oe, 0);
        do_write(9'h0C3);
        check(dout_oe == 1'b1, "R4", "oe after flow write", dout_oe, 1);
        check(dout == 9'h0C3, "R4", "flow word", dout, 9'h0C3);
        check(empty == 1'b0, "R4", "empty deasserted", empty, 0);
        rd_n = 1'b1;
        wait_cyc(4);
        check(empty == 1'b1, "R4", "empty reasserted", empty, 1);
        check(dout_oe == 1'b0, "R4", "oe after consume", dout_oe, 0);

        // Fill: R6 threshold and R5 full
        for (int i = 0; i < DEPTH; i++) begin
            do_write(pat(i));
            if (i == DEPTH / 2 - 1)
                check(half_full == 1'b0, "R6", "half at exactly half", half_full, 0);
            if (i == DEPTH / 2)
                check(half_full == 1'b1, "R6", "half above half", half_full, 1);
            if (i == DEPTH - 2)
                check(full == 1'b0, "R5", "full one short", full, 0);
        end
        check(full == 1'b1, "R5", "full at depth", full, 1);
        do_write(9'h1EE);
        check(full == 1'b1, "R5", "full after extra write", full, 1);

        // R7 write flow-through
        din  = 9'h1AB;
        wr_n = 1'b0;
        wait_cyc(4);
        rd_n = 1'b0;
        wait_cyc(4);
        q = dout;
        rd_n = 1'b1;
        check(q == pat(0), "R7", "head word from full", q, pat(0));
        saw_low = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!full) saw_low = 1'b1;
        end
        check(saw_low == 1'b1, "R7", "full pulse low", saw_low, 1);
        check(full == 1'b1, "R7", "full reasserted", full, 1);
        wr_n = 1'b1;
        wait_cyc(4);
        check(full == 1'b1, "R7", "full after pending write", full, 1);

        // Drain and compare order (R2), pending word last (R7), extra word absent (R5)
        for (int i = 1; i < DEPTH; i++) begin
            do_read(q, oe);
            check(q == pat(i), "R2", "drain order", q, pat(i));
        end
        do_read(q, oe);
        check(q == 9'h1AB, "R7", "pending word last", q, 9'h1AB);
        check(empty == 1'b1, "R5", "extra word not stored", empty, 1);
        check(half_full == 1'b0, "R6", "half after drain", half_full, 0);

        // R1 reset with content
        do_write(9'h011);
        do_write(9'h022);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
        check(empty == 1'b1, "R1", "empty after mid reset", empty, 1);
        check(full == 1'b0, "R1", "full after mid reset", full, 0);
        do_read(q, oe);
        check(oe == 1'b0, "R1", "no data after mid reset", oe, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule